// File: doc/BRIEF.md
# LCD Panel Power-Sequencing Controller

This block brings a small LCD panel up and down in a fixed, timed order and programs its registers through a 3-wire serial master. A power-up request turns the panel supply on and waits a settling time. It then releases the panel's active-low reset and writes the operating registers: mode, control, two drive registers, mirror, and the gamma curve. A power-down request first sends the panel to standby with its PWM still running. It then asserts reset, holds for a period that covers at least two frames, sends the final standby value, and turns the supply off.

Requests arrive as a one-cycle valid pulse with a 3-bit code and enter a small FIFO, so a request that comes in while the block is busy is not lost. Mode, mirror and gamma requests update internal settings in the cycle they arrive. If the panel is powered, they also produce the matching register writes. If it is off, the new values are kept for the next power-up. Pixel timing is not handled here.

Top module: `panel_power_seq`

## Requirements
- R1: Each register write is one 16-bit frame, sent MSB first in SPI mode 0 (clock idles low, data sampled on the rising edge). The frame carries the address in bits 15:10, 0 in bit 9, 1 in bit 8 and the data byte in bits 7:0. Chip-select is low for exactly 16 clock rises per frame and stays high for at least one SPI clock between frames.
- R2: Request code 1 (power on) raises `supplyEn`. It then waits at least ON_SETTLE_MS ms, counted in ticks of CLK_PER_MS clocks, before raising `panelRstN`. No frame is sent before that point.
- R3: After reset is released, power-on sends 20 frames in this order: address 0x02 with data {4'b0000, 1, mode}; address 0x03 with 0xDF; 0x20 with 0xF0; 0x21 with 0xF0; the mirror frame; then the 15 gamma frames of R5.
- R4: The mirror frame goes to address 0x04. Its data is 0x17, with bit 0 cleared when horizontal mirroring is on and bit 1 cleared when vertical mirroring is on.
- R5: Gamma holds 12 entries of 10 bits. For group g (0 to 2), bits 9:8 of entries 4g to 4g+3 fill data bits 7:6, 5:4, 3:2 and 1:0 of address 0x11+g. These three packed frames come first. Then the low bytes of entries 0 to 11 go to addresses 0x14 to 0x1F in ascending order.
- R6: Reset sets `supplyEn`, `panelRstN`, `busy` and `powered` low, holds chip-select high and clock low, and loads the defaults: mode 7, no mirroring, and gamma 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R7: Request code 2 (power off) sends address 0x03 with 0xD8 and then drives `panelRstN` low. After at least OFF_HOLD_MS ms it sends address 0x03 with 0xD0, and only then drops `supplyEn`.
- R8: A power-on request while powered, or a power-off request while unpowered, produces no frame and leaves the supply and reset pins as they are.
- R9: Code 3 captures `modeIn`, code 4 captures `mirrorH`/`mirrorV`, and code 5 captures `gammaIn` (entry i at bits 10i+9:10i), all at arrival. While powered, these produce one 0x02 frame, one 0x04 frame, or the 15 gamma frames respectively. While unpowered they produce no frame, and the captured values are used at the next power-on.
- R10: Requests are served in arrival order, one sequence at a time. Each queued update sends the settings as they stand when it is served. `busy` is high from the cycle after a request is accepted until its sequence ends, and no frame is sent while `busy` is low.
- R11: `powered` rises only after the last gamma frame of power-on has finished and falls when a power-off sequence starts. While `powered` is high, supply and reset are both released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqCode | input | 3 | 1 on, 2 off, 3 mode, 4 mirror, 5 gamma; other values ignored |
| modeIn | input | 3 | Mode value captured with code 3 |
| mirrorH | input | 1 | Horizontal mirror, captured with code 4 |
| mirrorV | input | 1 | Vertical mirror, captured with code 4 |
| gammaIn | input | 120 | Twelve 10-bit gamma entries, captured with code 5 |
| busy | output | 1 | A sequence is running or queued |
| powered | output | 1 | Panel is fully programmed and on |
| supplyEn | output | 1 | Panel supply enable |
| panelRstN | output | 1 | Panel reset, active low |
| spiCsN | output | 1 | Serial chip-select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |

## Verification
The bench sweeps every mode value and all four mirror combinations, and uses a gamma table whose high bits vary across all three packed groups. A wrong shift in the packed frames or a swapped group would show as mismatched data on addresses 0x11 to 0x13. It sends a power-on request while already on and a power-off request while already off; a design that failed to ignore them would resend the power-on script or toggle the supply. It stacks two mode updates behind a mirror update and queues a power-off behind a power-on. A FIFO that lost or reordered requests, or that used stale settings, would give the wrong frame list. It also times the settle and hold windows and sends updates while the panel is off, where any frame at all is a fault.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int GAMMA_N     = 12;
  localparam int GAMMA_W     = 10;
  localparam int GAMMA_GROUPS = GAMMA_N / 4;
  localparam int FRAME_BITS  = 16;
  localparam int SLOT_W      = 5;

  typedef enum logic [2:0] {
    REQ_NONE   = 3'd0,
    REQ_ON     = 3'd1,
    REQ_OFF    = 3'd2,
    REQ_MODE   = 3'd3,
    REQ_MIRROR = 3'd4,
    REQ_GAMMA  = 3'd5
  } reqCode_t;

  // Script slots: the order of the power-on writes is behaviour.
  localparam logic [SLOT_W-1:0] SLOT_MODE        = 5'd0;
  localparam logic [SLOT_W-1:0] SLOT_CTRL_RUN    = 5'd1;
  localparam logic [SLOT_W-1:0] SLOT_DRV_A       = 5'd2;
  localparam logic [SLOT_W-1:0] SLOT_DRV_B       = 5'd3;
  localparam logic [SLOT_W-1:0] SLOT_MIRROR      = 5'd4;
  localparam logic [SLOT_W-1:0] SLOT_GAMMA_FIRST = 5'd5;
  localparam logic [SLOT_W-1:0] SLOT_LOW_FIRST   = 5'd8;
  localparam logic [SLOT_W-1:0] SLOT_GAMMA_LAST  = 5'd19;
  localparam logic [SLOT_W-1:0] SLOT_STBY_PWM    = 5'd20;
  localparam logic [SLOT_W-1:0] SLOT_STBY        = 5'd21;

  localparam logic [5:0] ADDR_MODE     = 6'h02;
  localparam logic [5:0] ADDR_CTRL     = 6'h03;
  localparam logic [5:0] ADDR_MIRROR   = 6'h04;
  localparam logic [5:0] ADDR_GAMMA_HI = 6'h11;
  localparam logic [5:0] ADDR_GAMMA_LO = 6'h14;
  localparam logic [5:0] ADDR_DRV_A    = 6'h20;
  localparam logic [5:0] ADDR_DRV_B    = 6'h21;

  localparam logic [7:0] CTRL_RUN      = 8'hDF;
  localparam logic [7:0] CTRL_STBY_PWM = 8'hD8;
  localparam logic [7:0] CTRL_STBY     = 8'hD0;
  localparam logic [7:0] DRV_VALUE     = 8'hF0;
  localparam logic [7:0] MIRROR_BASE   = 8'h17;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_LAUNCH, S_SEND, S_OFF_HOLD
  } seqState_t;

  typedef enum logic [1:0] {
    OP_ON, OP_UPDATE, OP_OFF_A, OP_OFF_B
  } opKind_t;

  typedef enum logic [1:0] {
    L_IDLE, L_SHIFT, L_GAP
  } linkState_t;

  typedef struct packed {
    logic              frameGo;
    logic [SLOT_W-1:0] slot;
    logic              waitGo;
    logic              waitLong;
    logic              supplyOn;
    logic              supplyOff;
    logic              rstRelease;
    logic              rstAssert;
  } strobe_t;

  function automatic logic [FRAME_BITS-1:0] packFrame(logic [5:0] addr, logic [7:0] data);
    return {addr, 1'b0, 1'b1, data};
  endfunction

  function automatic logic [GAMMA_W-1:0] defaultGamma(int idx);
    case (idx)
      0:       return 10'd105;
      1:       return 10'd315;
      2:       return 10'd381;
      3:       return 10'd431;
      4:       return 10'd490;
      5:       return 10'd537;
      6:       return 10'd579;
      7:       return 10'd686;
      8:       return 10'd780;
      9:       return 10'd837;
      10:      return 10'd880;
      default: return 10'd1023;
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqCode,
  input  logic       frameDone,
  input  logic       waitDone,
  output strobe_t    stb,
  output logic       busy,
  output logic       powered
);

  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(QUEUE_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QUEUE_DEPTH);

  logic [2:0]        qMem [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  qCount;
  logic              codeOk, doPush, doPop;
  logic [2:0]        head;

  seqState_t         state, nState;
  opKind_t           op, nOp;
  logic [SLOT_W-1:0] slot, nSlot, lastSlot, nLast;
  logic              poweredR, nPow;

  assign codeOk = (reqCode >= 3'd1) && (reqCode <= 3'd5);
  assign doPush = reqValid && codeOk && (qCount != CNT_FULL);
  assign doPop  = (state == S_IDLE) && (qCount != '0);
  assign head   = qMem[rdPtr];

  // Request queue: arrival order is kept.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (doPush) begin
        qMem[wrPtr] <= reqCode;
        wrPtr       <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stb.slot = slot;
    nState   = state;
    nOp      = op;
    nSlot    = slot;
    nLast    = lastSlot;
    nPow     = poweredR;
    case (state)
      S_IDLE: begin
        if (doPop) begin
          case (head)
            REQ_ON: if (!poweredR) begin
              stb.supplyOn = 1'b1;
              stb.waitGo   = 1'b1;
              stb.waitLong = 1'b1;
              nState       = S_SETTLE;
            end
            REQ_OFF: if (poweredR) begin
              nPow   = 1'b0;
              nSlot  = SLOT_STBY_PWM;
              nLast  = SLOT_STBY_PWM;
              nOp    = OP_OFF_A;
              nState = S_LAUNCH;
            end
            REQ_MODE: if (poweredR) begin
              nSlot  = SLOT_MODE;
              nLast  = SLOT_MODE;
              nOp    = OP_UPDATE;
              nState = S_LAUNCH;
            end
            REQ_MIRROR: if (poweredR) begin
              nSlot  = SLOT_MIRROR;
              nLast  = SLOT_MIRROR;
              nOp    = OP_UPDATE;
              nState = S_LAUNCH;
            end
            REQ_GAMMA: if (poweredR) begin
              nSlot  = SLOT_GAMMA_FIRST;
              nLast  = SLOT_GAMMA_LAST;
              nOp    = OP_UPDATE;
              nState = S_LAUNCH;
            end
            default: ;
          endcase
        end
      end
      S_SETTLE: begin
        if (waitDone) begin
          stb.rstRelease = 1'b1;
          nSlot  = SLOT_MODE;
          nLast  = SLOT_GAMMA_LAST;
          nOp    = OP_ON;
          nState = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        stb.frameGo = 1'b1;
        nState      = S_SEND;
      end
      S_SEND: begin
        if (frameDone) begin
          if (slot != lastSlot) begin
            nSlot  = slot + 1'b1;
            nState = S_LAUNCH;
          end else begin
            case (op)
              OP_ON: begin
                nPow   = 1'b1;
                nState = S_IDLE;
              end
              OP_OFF_A: begin
                stb.rstAssert = 1'b1;
                stb.waitGo    = 1'b1;
                nState        = S_OFF_HOLD;
              end
              OP_OFF_B: begin
                stb.supplyOff = 1'b1;
                nState        = S_IDLE;
              end
              default: nState = S_IDLE;
            endcase
          end
        end
      end
      S_OFF_HOLD: begin
        if (waitDone) begin
          nSlot  = SLOT_STBY;
          nLast  = SLOT_STBY;
          nOp    = OP_OFF_B;
          nState = S_LAUNCH;
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      op       <= OP_UPDATE;
      slot     <= '0;
      lastSlot <= '0;
      poweredR <= 1'b0;
    end else begin
      state    <= nState;
      op       <= nOp;
      slot     <= nSlot;
      lastSlot <= nLast;
      poweredR <= nPow;
    end
  end

  assign busy    = (state != S_IDLE) || (qCount != '0);
  assign powered = poweredR;

endmodule

// File: rtl/panel_seq_dp.sv
module panel_seq_dp
  import panel_seq_pkg::*;
#(
  parameter int CLK_PER_MS   = 100000,
  parameter int SPI_DIV      = 4,
  parameter int ON_SETTLE_MS = 160,
  parameter int OFF_HOLD_MS  = 50
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic                       setValid,
  input  logic [2:0]                 setCode,
  input  logic [2:0]                 modeIn,
  input  logic                       mirrorH,
  input  logic                       mirrorV,
  input  logic [GAMMA_N*GAMMA_W-1:0] gammaIn,
  output logic                       frameDone,
  output logic                       waitDone,
  output logic                       supplyEn,
  output logic                       panelRstN,
  output logic                       spiCsN,
  output logic                       spiSclk,
  output logic                       spiMosi
);

  localparam int PRE_W  = $clog2(CLK_PER_MS) + 1;
  localparam int MAX_MS = (ON_SETTLE_MS > OFF_HOLD_MS) ? ON_SETTLE_MS : OFF_HOLD_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam int DIV_W  = $clog2(SPI_DIV) + 1;
  localparam int HALF_W = $clog2(2 * FRAME_BITS);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * FRAME_BITS - 1);

  // ---------------- settings ----------------
  logic [2:0]         modeReg;
  logic               mirHReg, mirVReg;
  logic [GAMMA_W-1:0] gammaReg [GAMMA_N];
  logic               loadMode, loadMirror, loadGamma;

  assign loadMode   = setValid && (setCode == REQ_MODE);
  assign loadMirror = setValid && (setCode == REQ_MIRROR);
  assign loadGamma  = setValid && (setCode == REQ_GAMMA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= 3'd7;
      mirHReg <= 1'b0;
      mirVReg <= 1'b0;
      for (int i = 0; i < GAMMA_N; i++) gammaReg[i] <= defaultGamma(i);
    end else begin
      if (loadMode) modeReg <= modeIn;
      if (loadMirror) begin
        mirHReg <= mirrorH;
        mirVReg <= mirrorV;
      end
      if (loadGamma)
        for (int i = 0; i < GAMMA_N; i++) gammaReg[i] <= gammaIn[i*GAMMA_W +: GAMMA_W];
    end
  end

  // ---------------- frame builder ----------------
  logic [7:0] packedHi [GAMMA_GROUPS];

  for (genvar g = 0; g < GAMMA_GROUPS; g++) begin : g_pack
    assign packedHi[g] = {gammaReg[4*g][9:8],   gammaReg[4*g+1][9:8],
                          gammaReg[4*g+2][9:8], gammaReg[4*g+3][9:8]};
  end

  logic [FRAME_BITS-1:0] frameWord;
  logic [SLOT_W-1:0]     hiRel, loRel;
  logic [1:0]            hiIdx;
  logic [3:0]            loIdx;

  always_comb begin
    hiRel = stb.slot - SLOT_GAMMA_FIRST;
    loRel = stb.slot - SLOT_LOW_FIRST;
    hiIdx = hiRel[1:0];
    loIdx = loRel[3:0];
    if (stb.slot == SLOT_MODE)
      frameWord = packFrame(ADDR_MODE, {4'b0000, 1'b1, modeReg});
    else if (stb.slot == SLOT_CTRL_RUN)
      frameWord = packFrame(ADDR_CTRL, CTRL_RUN);
    else if (stb.slot == SLOT_DRV_A)
      frameWord = packFrame(ADDR_DRV_A, DRV_VALUE);
    else if (stb.slot == SLOT_DRV_B)
      frameWord = packFrame(ADDR_DRV_B, DRV_VALUE);
    else if (stb.slot == SLOT_MIRROR)
      frameWord = packFrame(ADDR_MIRROR, MIRROR_BASE & ~{6'b000000, mirVReg, mirHReg});
    else if (stb.slot < SLOT_LOW_FIRST)
      frameWord = packFrame(ADDR_GAMMA_HI + {4'b0000, hiIdx}, packedHi[hiIdx]);
    else if (stb.slot <= SLOT_GAMMA_LAST)
      frameWord = packFrame(ADDR_GAMMA_LO + {2'b00, loIdx}, gammaReg[loIdx][7:0]);
    else if (stb.slot == SLOT_STBY_PWM)
      frameWord = packFrame(ADDR_CTRL, CTRL_STBY_PWM);
    else
      frameWord = packFrame(ADDR_CTRL, CTRL_STBY);
  end

  // ---------------- serial link ----------------
  linkState_t            linkState;
  logic [DIV_W-1:0]      divCnt;
  logic [HALF_W-1:0]     halfCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  divTick;

  assign divTick = (divCnt == DIV_W'(SPI_DIV - 1));

  always_ff @(posedge clk) begin
    frameDone <= 1'b0;
    if (!rstN) begin
      linkState <= L_IDLE;
      divCnt    <= '0;
      halfCnt   <= '0;
      shiftReg  <= '0;
      spiCsN    <= 1'b1;
      spiSclk   <= 1'b0;
    end else begin
      divCnt <= (linkState == L_IDLE || divTick) ? '0 : divCnt + 1'b1;
      case (linkState)
        L_IDLE: begin
          if (stb.frameGo) begin
            shiftReg  <= frameWord;
            spiCsN    <= 1'b0;
            spiSclk   <= 1'b0;
            halfCnt   <= '0;
            linkState <= L_SHIFT;
          end
        end
        L_SHIFT: begin
          if (divTick) begin
            halfCnt <= halfCnt + 1'b1;
            if (!halfCnt[0]) begin
              spiSclk <= 1'b1;
            end else begin
              spiSclk <= 1'b0;
              if (halfCnt == HALF_LAST) begin
                spiCsN    <= 1'b1;
                halfCnt   <= '0;
                linkState <= L_GAP;
              end else begin
                shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
              end
            end
          end
        end
        L_GAP: begin
          if (divTick) begin
            halfCnt <= halfCnt + 1'b1;
            if (halfCnt == HALF_W'(1)) begin
              frameDone <= 1'b1;
              linkState <= L_IDLE;
            end
          end
        end
        default: linkState <= L_IDLE;
      endcase
    end
  end

  assign spiMosi = shiftReg[FRAME_BITS-1];

  // ---------------- millisecond timer ----------------
  logic             timerOn;
  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msLeft;

  always_ff @(posedge clk) begin
    waitDone <= 1'b0;
    if (!rstN) begin
      timerOn <= 1'b0;
      preCnt  <= '0;
      msLeft  <= '0;
    end else if (stb.waitGo) begin
      timerOn <= 1'b1;
      preCnt  <= '0;
      msLeft  <= stb.waitLong ? MS_W'(ON_SETTLE_MS) : MS_W'(OFF_HOLD_MS);
    end else if (timerOn) begin
      if (preCnt == PRE_W'(CLK_PER_MS - 1)) begin
        preCnt <= '0;
        if (msLeft == MS_W'(1)) begin
          timerOn  <= 1'b0;
          waitDone <= 1'b1;
        end else begin
          msLeft <= msLeft - 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // ---------------- panel pins ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      supplyEn  <= 1'b0;
      panelRstN <= 1'b0;
    end else begin
      if (stb.supplyOn)        supplyEn  <= 1'b1;
      else if (stb.supplyOff)  supplyEn  <= 1'b0;
      if (stb.rstRelease)      panelRstN <= 1'b1;
      else if (stb.rstAssert)  panelRstN <= 1'b0;
    end
  end

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int CLK_PER_MS   = 100000,
  parameter int SPI_DIV      = 4,
  parameter int ON_SETTLE_MS = 160,
  parameter int OFF_HOLD_MS  = 50,
  parameter int QUEUE_DEPTH  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [2:0]   reqCode,
  input  logic [2:0]   modeIn,
  input  logic         mirrorH,
  input  logic         mirrorV,
  input  logic [119:0] gammaIn,
  output logic         busy,
  output logic         powered,
  output logic         supplyEn,
  output logic         panelRstN,
  output logic         spiCsN,
  output logic         spiSclk,
  output logic         spiMosi
);

  strobe_t stb;
  logic    frameDone, waitDone;

  panel_seq_ctrl #(
    .QUEUE_DEPTH(QUEUE_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqCode  (reqCode),
    .frameDone(frameDone),
    .waitDone (waitDone),
    .stb      (stb),
    .busy     (busy),
    .powered  (powered)
  );

  panel_seq_dp #(
    .CLK_PER_MS  (CLK_PER_MS),
    .SPI_DIV     (SPI_DIV),
    .ON_SETTLE_MS(ON_SETTLE_MS),
    .OFF_HOLD_MS (OFF_HOLD_MS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .setValid (reqValid),
    .setCode  (reqCode),
    .modeIn   (modeIn),
    .mirrorH  (mirrorH),
    .mirrorV  (mirrorV),
    .gammaIn  (gammaIn),
    .frameDone(frameDone),
    .waitDone (waitDone),
    .supplyEn (supplyEn),
    .panelRstN(panelRstN),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi)
  );

endmodule

// File: rtl/panel_seq_checker.sv
module panel_seq_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic powered,
  input logic supplyEn,
  input logic panelRstN,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi
);

  logic       sclkQ;
  logic [5:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      riseCnt <= '0;
    end else begin
      sclkQ <= spiSclk;
      if (spiCsN)                 riseCnt <= '0;
      else if (spiSclk && !sclkQ) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R1: sixteen clock rises inside every chip-select window
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> (riseCnt == 6'd16));

  // R1: clock idles low outside a frame
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R1: data held while the clock is high
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSclk) |-> $stable(spiMosi));

  // R2: no serial traffic without supply
  assert_no_spi_unpowered_R2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyEn |-> spiCsN);

  // R2: reset released only with supply on
  assert_rst_needs_supply_R2: assert property (@(posedge clk) disable iff (!rstN)
    panelRstN |-> supplyEn);

  // R11: powered implies supply and reset released
  assert_powered_pins_R11: assert property (@(posedge clk) disable iff (!rstN)
    powered |-> (supplyEn && panelRstN));

  // R10: frames only while busy
  assert_frame_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

endmodule

bind panel_power_seq panel_seq_checker u_check (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .powered  (powered),
  .supplyEn (supplyEn),
  .panelRstN(panelRstN),
  .spiCsN   (spiCsN),
  .spiSclk  (spiSclk),
  .spiMosi  (spiMosi)
);

// File: tb/sim_panel_power_seq.sv
module sim_panel_power_seq;

  localparam int MS_CLK = 4;
  localparam int DIV    = 1;
  localparam int ON_MS  = 160;
  localparam int OFF_MS = 50;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [2:0]   reqCode = 3'd0;
  logic [2:0]   modeIn = 3'd0;
  logic         mirrorH = 1'b0;
  logic         mirrorV = 1'b0;
  logic [119:0] gammaIn = '0;
  logic         busy, powered, supplyEn, panelRstN, spiCsN, spiSclk, spiMosi;

  always #2 clk = ~clk;

  panel_power_seq #(
    .CLK_PER_MS(MS_CLK), .SPI_DIV(DIV), .ON_SETTLE_MS(ON_MS),
    .OFF_HOLD_MS(OFF_MS), .QUEUE_DEPTH(4)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .modeIn(modeIn), .mirrorH(mirrorH), .mirrorV(mirrorV), .gammaIn(gammaIn),
    .busy(busy), .powered(powered), .supplyEn(supplyEn), .panelRstN(panelRstN),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // ---- serial monitor ----
  logic [15:0] capQ [$];
  logic [15:0] sh = '0;
  int bitCnt = 0;
  int badLen = 0;

  always @(posedge spiSclk) if (spiCsN === 1'b0) begin
    sh = {sh[14:0], spiMosi};
    bitCnt++;
  end
  always @(negedge spiCsN) bitCnt = 0;
  always @(posedge spiCsN) if (bitCnt > 0) begin
    capQ.push_back(sh);
    if (bitCnt != 16) badLen++;
    bitCnt = 0;
  end

  // ---- reference model state ----
  int tbMode = 7;
  bit tbH = 0, tbV = 0;
  int tbG [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};

  function automatic int mk(int addr, int data);
    return ((addr << 10) | 256 | (data & 255)) & 16'hFFFF;
  endfunction

  function automatic int expSlot(int s);
    int v;
    if (s == 0) return mk(2, 8 | tbMode);
    if (s == 1) return mk(3, 'hDF);
    if (s == 2) return mk('h20, 'hF0);
    if (s == 3) return mk('h21, 'hF0);
    if (s == 4) return mk(4, 'h17 & ~((tbH ? 1 : 0) | (tbV ? 2 : 0)));
    if (s < 8) begin
      v = 0;
      for (int k = 0; k < 4; k++) v |= ((tbG[4*(s-5)+k] >> 8) & 3) << (6 - 2*k);
      return mk('h11 + s - 5, v);
    end
    return mk('h14 + s - 8, tbG[s-8] & 255);
  endfunction

  task automatic cmp(string req, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendReq(int code);
    @(negedge clk);
    reqValid = 1'b1;
    reqCode  = 3'(code);
    @(negedge clk);
    reqValid = 1'b0;
    reqCode  = 3'd0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // compare captured frames with slots lo..hi, then extras
  task automatic checkScript(string req, int lo, int hi, int extraA, int extraB);
    int n;
    n = hi - lo + 1 + (extraA >= 0 ? 1 : 0) + (extraB >= 0 ? 1 : 0);
    if (hi < lo) n = (extraA >= 0 ? 1 : 0) + (extraB >= 0 ? 1 : 0);
    cmp({req, " frame count"}, capQ.size(), n);
    if (capQ.size() == n) begin
      int p = 0;
      for (int s = lo; s <= hi; s++) begin
        cmp(req, int'(capQ[p]), expSlot(s));
        p++;
      end
      if (extraA >= 0) begin cmp(req, int'(capQ[p]), extraA); p++; end
      if (extraB >= 0) cmp(req, int'(capQ[p]), extraB);
    end
    capQ.delete();
  endtask

  task automatic driveGamma();
    for (int i = 0; i < 12; i++) gammaIn[i*10 +: 10] = 10'(tbG[i]);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: reset state
    cmp("R6 supplyEn", supplyEn, 0);
    cmp("R6 panelRstN", panelRstN, 0);
    cmp("R6 spiCsN", spiCsN, 1);
    cmp("R6 spiSclk", spiSclk, 0);
    cmp("R6 busy", busy, 0);
    cmp("R6 powered", powered, 0);

    // R8: power-off while off does nothing
    sendReq(2);
    waitIdle();
    cmp("R8 off-while-off frames", capQ.size(), 0);
    cmp("R8 off-while-off supply", supplyEn, 0);

    // R2: settle window before reset release, no frames before it
    sendReq(1);
    n = 0;
    while (!panelRstN) begin
      @(negedge clk);
      if (supplyEn && !panelRstN) n++;
    end
    cmp("R2 settle window", (n >= ON_MS*MS_CLK && n <= ON_MS*MS_CLK + 5) ? 1 : 0, 1);
    cmp("R2 no frame before release", capQ.size(), 0);
    cmp("R11 powered low during script", powered, 0);
    waitIdle();
    // R3 R4 R5 R6: power-on script with default settings
    checkScript("R3 power-on defaults", 0, 19, -1, -1);
    cmp("R11 powered after script", powered, 1);

    // R8: power-on while on does nothing
    sendReq(1);
    waitIdle();
    cmp("R8 on-while-on frames", capQ.size(), 0);
    cmp("R8 on-while-on reset pin", panelRstN, 1);

    // R9: every mode value, one frame each
    for (int m = 0; m < 8; m++) begin
      modeIn = 3'(m);
      tbMode = m;
      sendReq(3);
      waitIdle();
      checkScript("R9 mode update", 0, 0, -1, -1);
    end

    // R4 R9: all mirror combinations
    for (int c = 0; c < 4; c++) begin
      mirrorH = c[0];
      mirrorV = c[1];
      tbH = c[0];
      tbV = c[1];
      sendReq(4);
      waitIdle();
      checkScript("R4 mirror update", 4, 4, -1, -1);
    end

    // R5 R9: gamma update with varied high bits
    for (int i = 0; i < 12; i++) tbG[i] = (i * 331 + 47) % 1024;
    tbG[0] = 1023;
    tbG[11] = 0;
    driveGamma();
    sendReq(5);
    waitIdle();
    checkScript("R5 gamma update", 5, 19, -1, -1);

    // R10: queued requests in arrival order, latest settings at service
    mirrorH = 1'b1; mirrorV = 1'b0; tbH = 1; tbV = 0;
    sendReq(4);
    cmp("R10 busy after accept", busy, 1);
    modeIn = 3'd3;
    sendReq(3);
    modeIn = 3'd6;
    sendReq(3);
    tbMode = 6;
    waitIdle();
    checkScript("R10 queued order", 4, 4, expSlot(0), expSlot(0));

    // R7 R11: power-off order and hold window
    sendReq(2);
    repeat (3) @(negedge clk);
    cmp("R11 powered low at off start", powered, 0);
    while (panelRstN) @(negedge clk);
    cmp("R7 first standby before reset", capQ.size(), 1);
    n = 0;
    while (spiCsN) begin
      @(negedge clk);
      n++;
    end
    cmp("R7 hold window", (n >= OFF_MS*MS_CLK && n <= OFF_MS*MS_CLK + 6) ? 1 : 0, 1);
    cmp("R7 supply held during last write", supplyEn, 1);
    waitIdle();
    checkScript("R7 power-off frames", 1, 0, mk(3, 'hD8), mk(3, 'hD0));
    cmp("R7 supply off", supplyEn, 0);
    cmp("R7 reset low", panelRstN, 0);

    // R9: updates while off send nothing, values used at next power-on
    modeIn = 3'd1; tbMode = 1;
    sendReq(3);
    mirrorH = 1'b0; mirrorV = 1'b1; tbH = 0; tbV = 1;
    sendReq(4);
    waitIdle();
    cmp("R9 no frames while off", capQ.size(), 0);

    // R10: power-on then power-off queued back to back
    sendReq(1);
    sendReq(2);
    waitIdle();
    checkScript("R10 on then off", 0, 19, mk(3, 'hD8), mk(3, 'hD0));
    cmp("R10 final supply", supplyEn, 0);
    cmp("R10 final powered", powered, 0);

    // R1: every captured frame had sixteen bits
    cmp("R1 frame length", badLen, 0);

    finishRun();
  end

endmodule